// File: doc/BRIEF.md
# Hard-Decision Branch Metric and Add-Compare-Select Unit

This block is the metric datapath of a hard-decision Viterbi decoder for a rate 1/2 convolutional code with constraint length 3, giving a four-state trellis. For every accepted 2-bit received symbol it forms the Hamming distance to each of the four possible transition outputs. It then runs one add-compare-select per trellis state. It returns the four updated path metrics and one survivor decision bit per state. A survivor storage unit downstream consumes the decisions.

Symbols enter on a valid/ready stream and results leave on a second valid/ready stream, with a single register stage between them. A result that has not been taken holds the output register. While it is held, the input side is not ready, so upstream must keep its symbol, start flag and valid steady until it sees ready. A start-of-frame flag travels with a symbol and makes that step begin from the all-zero state. Path metrics are kept bounded by subtracting the smallest metric once it reaches half of full scale.

Top module: `vmc_metric_core`

## Requirements
- R1: After synchronous reset `out_valid` is 0 and `in_ready` is 1, and the stored metrics are 0 for state 0 and 2^(PM_W-2) (16 by default) for states 1 to 3, so a first symbol without a start flag decodes from state 0.
- R2: The expected symbol for leaving state p = {p[1],p[0]} with input bit u is {u^p[1]^p[0], u^p[0]}, where bit 1 is the output of generator 1+X+X^2 and bit 0 the output of generator 1+X^2. On an error-free encoded stream that starts from the all-zero state, the metric of the encoder's true state is 0 after every step.
- R3: A state holds the two latest input bits, with the newest in bit 1, and the next state is {u, p[1]}. State n therefore has the predecessors 2*n[0] (decision 0) and 2*n[0]+1 (decision 1), and its input bit is n[1]. `out_dec[n]` and `out_pm[n*PM_W +: PM_W]` belong to state n.
- R4: Each new metric is the smaller of the two sums, where a sum is the predecessor's metric plus the branch metric, and a branch metric is the count of differing bits (0, 1 or 2). The decision bit is 1 exactly when the odd predecessor's sum is strictly smaller.
- R5: When both sums are equal, the decision bit is 0.
- R6: A symbol accepted with `in_sof`=1 uses the metrics 0, 16, 16, 16 in place of the stored ones.
- R7: If the smallest of the four new sums is at least 2^(PM_W-1) (32), it is subtracted from all four before they are stored. Otherwise the sums are stored unchanged.
- R8: A symbol is accepted when `in_valid` and `in_ready` are both 1 at a clock edge. Its metrics and decisions appear, with `out_valid`=1, right after that edge.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady. `out_valid` falls after a taken result when no new symbol is accepted.
- R10: While `in_valid` is 0, `in_sym` and `in_sof` have no effect: the next accepted symbol continues from the stored metrics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Symbol valid |
| in_ready | output | 1 | Block can take a symbol |
| in_sym | input | 2 | Received hard-decision symbol (bit 1 first generator) |
| in_sof | input | 1 | Start of frame, qualified by the symbol handshake |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_pm | output | 4*PM_W | Path metrics, state n at bits n*PM_W +: PM_W |
| out_dec | output | 4 | Survivor decisions, bit n for state n |

## Verification
Two functions can fall in the same update: metric renormalization and a tied compare. Ties must be resolved on the raw sums, and the subtraction must leave each state's winner unchanged. A long unframed run of random symbols pushes the minimum metric past half scale while ties keep occurring. Every result is compared with a bench model that computes sums, ties and subtraction on its own. A second pairing, a stalled output with a new symbol offered, is provoked by random `out_ready` and is judged by the hold of the outputs and the value of `in_ready`.

// File: rtl/vmc_pkg.sv
`timescale 1ns/1ps
package vmc_pkg;
  localparam int CONSTR_LEN = 3;
  localparam int MEM_LEN    = CONSTR_LEN - 1;
  localparam int NUM_ST     = 1 << MEM_LEN;
  localparam int SYM_W      = 2;
  localparam int NUM_CODES  = 1 << SYM_W;
  localparam int BM_W       = 2;

  // Transition output for leaving state prev with input bit_in.
  // Bit 1: generator 1+X+X^2, bit 0: generator 1+X^2.
  function automatic logic [SYM_W-1:0] branch_code(input logic [MEM_LEN-1:0] prev,
                                                   input logic bit_in);
    return {bit_in ^ prev[1] ^ prev[0], bit_in ^ prev[0]};
  endfunction
endpackage

// File: rtl/vmc_branch_metric.sv
`timescale 1ns/1ps
module vmc_branch_metric
  import vmc_pkg::*;
(
  input  logic [SYM_W-1:0]          sym,
  output logic [NUM_CODES*BM_W-1:0] bm_flat
);
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    logic [SYM_W-1:0] diff;
    assign diff = sym ^ SYM_W'(c);
    always_comb begin
      bm_flat[c*BM_W +: BM_W] = '0;
      for (int b = 0; b < SYM_W; b++)
        bm_flat[c*BM_W +: BM_W] = bm_flat[c*BM_W +: BM_W] + BM_W'(diff[b]);
    end
  end
endmodule

// File: rtl/vmc_acs_cell.sv
`timescale 1ns/1ps
module vmc_acs_cell
  import vmc_pkg::*;
#(
  parameter int PM_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PM_W-1:0] pm_a,
  input  logic [PM_W-1:0] pm_b,
  input  logic [BM_W-1:0] bm_a,
  input  logic [BM_W-1:0] bm_b,
  output logic [PM_W:0]   sum_sel,
  output logic            dec
);
  logic [PM_W:0] sum_a, sum_b;

  assign sum_a   = {1'b0, pm_a} + (PM_W+1)'(bm_a);
  assign sum_b   = {1'b0, pm_b} + (PM_W+1)'(bm_b);
  assign dec     = (sum_b < sum_a);
  assign sum_sel = dec ? sum_b : sum_a;

  AST_SEL_IS_MIN: assert property (@(posedge clk) disable iff (rst)
    (sum_sel <= sum_a) && (sum_sel <= sum_b)); // R4
  AST_TIE_LOWER: assert property (@(posedge clk) disable iff (rst)
    (pm_a + bm_a == pm_b + bm_b) && ({1'b0,pm_a} + bm_a == sum_sel) |-> !dec); // R5
endmodule

// File: rtl/vmc_renorm.sv
`timescale 1ns/1ps
module vmc_renorm
  import vmc_pkg::*;
#(
  parameter int PM_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_ST*(PM_W+1)-1:0] sums,
  output logic [NUM_ST*PM_W-1:0]     pm_out
);
  localparam int SW = PM_W + 1;
  localparam logic [SW-1:0] HALF = SW'(1 << (PM_W-1));

  logic [SW-1:0] lo;
  logic          do_sub;

  always_comb begin
    lo = sums[0 +: SW];
    for (int s = 1; s < NUM_ST; s++)
      if (sums[s*SW +: SW] < lo) lo = sums[s*SW +: SW];
    do_sub = (lo >= HALF);
    for (int s = 0; s < NUM_ST; s++)
      pm_out[s*PM_W +: PM_W] = PM_W'(sums[s*SW +: SW] - (do_sub ? lo : '0));
  end

  for (genvar s = 0; s < NUM_ST; s++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      sums[s*SW+PM_W] == 1'b0); // R7
  end
endmodule

// File: rtl/vmc_metric_core.sv
`timescale 1ns/1ps
module vmc_metric_core
  import vmc_pkg::*;
#(
  parameter int PM_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             in_sym,
  input  logic                   in_sof,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [4*PM_W-1:0]      out_pm,
  output logic [3:0]             out_dec
);
  localparam int SW = PM_W + 1;
  localparam logic [PM_W-1:0] INIT_PM = PM_W'(1 << (PM_W-2));
  localparam logic [PM_W-1:0] HALF    = PM_W'(1 << (PM_W-1));

  logic [PM_W-1:0]              pm_q   [NUM_ST];
  logic [PM_W-1:0]              old_pm [NUM_ST];
  logic [NUM_CODES*BM_W-1:0]    bm_flat;
  logic [NUM_ST*SW-1:0]         sums_flat;
  logic [NUM_ST*PM_W-1:0]       pm_new_flat;
  logic [NUM_ST-1:0]            dec_w;
  logic                         accept;
  logic [PM_W-1:0]              lowest_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    for (int s = 0; s < NUM_ST; s++) begin
      if (in_sof) old_pm[s] = (s == 0) ? '0 : INIT_PM;
      else        old_pm[s] = pm_q[s];
      out_pm[s*PM_W +: PM_W] = pm_q[s];
    end
  end

  vmc_branch_metric u_bm (
    .sym     (in_sym),
    .bm_flat (bm_flat)
  );

  for (genvar n = 0; n < NUM_ST; n++) begin : g_state
    localparam int PA = 2 * (n % 2);
    localparam int PB = PA + 1;
    localparam int CA = int'(branch_code(MEM_LEN'(PA), 1'(n / 2)));
    localparam int CB = int'(branch_code(MEM_LEN'(PB), 1'(n / 2)));
    vmc_acs_cell #(.PM_W(PM_W)) u_acs (
      .clk     (clk),
      .rst     (rst),
      .pm_a    (old_pm[PA]),
      .pm_b    (old_pm[PB]),
      .bm_a    (bm_flat[CA*BM_W +: BM_W]),
      .bm_b    (bm_flat[CB*BM_W +: BM_W]),
      .sum_sel (sums_flat[n*SW +: SW]),
      .dec     (dec_w[n])
    );
  end

  vmc_renorm #(.PM_W(PM_W)) u_norm (
    .clk    (clk),
    .rst    (rst),
    .sums   (sums_flat),
    .pm_out (pm_new_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_ST; s++) pm_q[s] <= (s == 0) ? '0 : INIT_PM;
      out_dec   <= '0;
      out_valid <= 1'b0;
    end else if (accept) begin
      for (int s = 0; s < NUM_ST; s++) pm_q[s] <= pm_new_flat[s*PM_W +: PM_W];
      out_dec   <= dec_w;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_comb begin
    lowest_q = pm_q[0];
    for (int s = 1; s < NUM_ST; s++)
      if (pm_q[s] < lowest_q) lowest_q = pm_q[s];
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pm) && $stable(out_dec)); // R9
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R8
  AST_MIN_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lowest_q < HALF); // R7
  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_sof |=> out_pm[PM_W-1:0] <= PM_W'(2)); // R6
endmodule

// File: tb/tb_vmc_metric_core.sv
`timescale 1ns/1ps
module tb_vmc_metric_core;
  localparam int PM_W = 6;
  localparam int INIT = 1 << (PM_W-2);
  localparam int HALF = 1 << (PM_W-1);

  logic clk = 1'b0;
  logic rst, in_valid, in_sof, out_ready;
  logic [1:0] in_sym;
  logic in_ready, out_valid;
  logic [4*PM_W-1:0] out_pm;
  logic [3:0] out_dec;

  always #2.5 clk = ~clk;

  vmc_metric_core #(.PM_W(PM_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_pm(out_pm), .out_dec(out_dec)
  );

  int checks = 0, errors = 0;
  int ref_pm [4];
  int exp_pm [4];
  bit [3:0] exp_dec;
  bit exp_ov;
  string pm_tag, dec_tag;
  int zero_state;   // -1: none
  int enc_st;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int code_of(input int p, input int u);
    return (((u ^ (p >> 1) ^ p) & 1) << 1) | ((u ^ p) & 1);
  endfunction

  function automatic int hd(input int a, input int b);
    int d = a ^ b;
    return (d & 1) + ((d >> 1) & 1);
  endfunction

  task automatic model_step(input int sym, input bit sof, input string base);
    int old [4];
    int sums [4];
    int lo;
    bit tie = 0;
    for (int s = 0; s < 4; s++) old[s] = sof ? ((s == 0) ? 0 : INIT) : ref_pm[s];
    for (int n = 0; n < 4; n++) begin
      int u = n >> 1;
      int pa = 2 * (n & 1);
      int pb = pa + 1;
      int sa = old[pa] + hd(sym, code_of(pa, u));
      int sb = old[pb] + hd(sym, code_of(pb, u));
      if (sa == sb) tie = 1;
      exp_dec[n] = (sb < sa);
      sums[n] = (sb < sa) ? sb : sa;
    end
    lo = sums[0];
    for (int s = 1; s < 4; s++) if (sums[s] < lo) lo = sums[s];
    for (int s = 0; s < 4; s++) begin
      ref_pm[s] = (lo >= HALF) ? sums[s] - lo : sums[s];
      exp_pm[s] = ref_pm[s];
    end
    pm_tag  = sof ? "R6" : (lo >= HALF) ? "R7" : base;
    dec_tag = tie ? "R5" : "R3";
    exp_ov  = 1;
  endtask

  task automatic check_outputs();
    chk(out_valid == exp_ov, "R8 out_valid", int'(out_valid), int'(exp_ov));
    if (exp_ov) begin
      for (int s = 0; s < 4; s++)
        chk(int'(out_pm[s*PM_W +: PM_W]) == exp_pm[s], pm_tag,
            int'(out_pm[s*PM_W +: PM_W]), exp_pm[s]);
      chk(out_dec == exp_dec, dec_tag, int'(out_dec), int'(exp_dec));
      if (zero_state >= 0)
        chk(int'(out_pm[zero_state*PM_W +: PM_W]) == 0, "R2 true-state metric",
            int'(out_pm[zero_state*PM_W +: PM_W]), 0);
    end
  endtask

  // One cycle: check outputs at the falling edge, drive, predict the rising edge.
  task automatic cycle(input bit v, input int sym, input bit sof, input bit rdy,
                       input string base, input int zs);
    bit exp_rdy;
    @(negedge clk);
    check_outputs();
    in_valid = v; in_sym = sym[1:0]; in_sof = sof; out_ready = rdy;
    #1;
    exp_rdy = !exp_ov || rdy;
    chk(in_ready == exp_rdy, "R9 in_ready", int'(in_ready), int'(exp_rdy));
    if (v && exp_rdy) begin
      model_step(sym, sof, base);
      zero_state = zs;
    end else if (rdy) begin
      exp_ov = 0;
    end
  endtask

  // Keep offering one symbol until accepted.
  task automatic send(input int sym, input bit sof, input bit rdy_rand,
                      input string base, input int zs);
    bit done = 0;
    while (!done) begin
      bit rdy = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      bit will = !exp_ov || rdy;
      cycle(1'b1, sym, sof, rdy, base, zs);
      done = will;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst = 1; in_valid = 0; in_sym = 0; in_sof = 0; out_ready = 1;
    zero_state = -1; exp_ov = 0;
    for (int s = 0; s < 4; s++) ref_pm[s] = (s == 0) ? 0 : INIT;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);

    // R1: first symbol after reset, no start flag, starts from state 0
    send(2'b11, 1'b0, 1'b0, "R1", -1);
    send(2'b01, 1'b0, 1'b0, "R4", -1);

    // R2/R6: error-free encoded frame from the zero state
    enc_st = 0;
    for (int i = 0; i < 40; i++) begin
      int u = $urandom % 2;
      int c = code_of(enc_st, u);
      enc_st = (u << 1) | (enc_st >> 1);
      send(c, (i == 0), 1'b0, "R2", enc_st);
    end
    zero_state = -1;

    // R10: idle cycles with junk on symbol and start flag
    for (int i = 0; i < 4; i++) cycle(1'b0, $urandom % 4, 1'b1, 1'b1, "R10", -1);
    send(2'b10, 1'b0, 1'b0, "R10", -1);

    // R9: random stalls and gaps mixed with frames
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 10) < 7)
        send($urandom % 4, (($urandom % 32) == 0), 1'b1, "R4", -1);
      else
        cycle(1'b0, $urandom % 4, $urandom % 2, ($urandom % 2), "R10", -1);
    end

    // R7/R5: long unframed noisy run drives renormalization with ties
    for (int i = 0; i < 300; i++) send($urandom % 4, 1'b0, 1'b0, "R4", -1);

    // R9: hold under a long stall
    send(2'b00, 1'b1, 1'b0, "R6", -1);
    for (int i = 0; i < 5; i++) cycle(1'b1, 2'b11, 1'b0, 1'b0, "R9", -1);
    cycle(1'b0, 0, 1'b0, 1'b1, "R9", -1);
    cycle(1'b0, 0, 1'b0, 1'b1, "R9", -1);
    @(negedge clk);
    check_outputs();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule